// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block merges four interrupt causes of a serial port into one active-high interrupt line and an 8-bit identification value that names the most urgent enabled cause. The causes are a receive line error, a received character waiting, an empty transmit holding register and a change on the modem status lines. The neighbouring receiver, transmitter and modem logic produce the cause conditions. The host bus decode produces single-cycle strobes for the register accesses that clear each cause.

Line error, received data and modem change arrive as one-cycle event pulses and are held as sticky pending flags. The transmit cause is edge-driven from a level that reports the holding register as empty. It also fires when its enable bit is turned on while the register is already empty. It clears on a holding-register write, or on an identification read that reported it. A 4-bit enable register masks the pending flags. The identification value is registered, and it is frozen for as long as a read strobe stays high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset `ier_o` is 0x00, `iir_o` is 0x01 and `irq_o` is 0.
- R2: An enable write stores bits 3:0 of the written data: bit 0 is received data, bit 1 is transmit empty, bit 2 is line error and bit 3 is modem change. Bits 7:4 of `ier_o` always read 0.
- R3: `irq_o` is 1 exactly when at least one pending cause is also enabled. It follows the clock edge that changes pending or enable state.
- R4: The low three bits of `iir_o` encode the highest enabled pending cause, in the priority order line error > received data > transmit empty > modem change. The codes are line error 110, received data 100, transmit empty 010, modem change 000, and 001 when nothing is pending. Bits 7:3 read 0.
- R5: A line status read clears the line error cause. A receive buffer read clears the received data cause. A modem status read clears the modem change cause.
- R6: The transmit-empty cause is set when `thr_empty_i` rises, and it is cleared by `thr_wr_i`.
- R7: An identification read clears the transmit-empty cause only if the `iir_o` value shown during that read carried code 010.
- R8: After an identification read has cleared the transmit-empty cause, it stays clear while `thr_empty_i` stays high. It is raised again only after a write followed by a new rise of `thr_empty_i`.
- R9: Writing enable bit 1 from 0 to 1 while `thr_empty_i` is high sets the transmit-empty cause at that edge.
- R10: While `iir_rd_i` is held high, `iir_o` does not change, even if new causes arrive.
- R11: A disabled cause does not drive `irq_o`, but it stays pending. Enabling it later raises `irq_o`.
- R12: An event pulse in the same cycle as its clearing read leaves the cause pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lsr_evt_i | input | 1 | Line error event pulse |
| rx_evt_i | input | 1 | Received data event pulse |
| msr_evt_i | input | 1 | Modem status change event pulse |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| lsr_rd_i | input | 1 | Line status read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification read strobe |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register read value |
| iir_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
An event, a clearing strobe or an enable write changes `irq_o` at the edge that samples it. `iir_o` needs one more edge, because it is registered. The bench drives inputs on falling edges and checks `irq_o` after the first rising edge. It checks `iir_o` only after the second rising edge, once the strobe has been dropped. The one exception is a read in progress: there the bench compares `iir_o` against the value captured before the strobe, for every cycle the strobe is held.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 4;
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef enum logic [2:0] {
    IID_MS   = 3'b000,
    IID_NONE = 3'b001,
    IID_TX   = 3'b010,
    IID_RX   = 3'b100,
    IID_LS   = 3'b110
  } iid_e;
endpackage

// File: rtl/irq_sticky_src.sv
module irq_sticky_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;  // a new event beats a same-cycle clear
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R12
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  // R5
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/irq_thre_src.sv
module irq_thre_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic arm_i,
  input  logic wr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic empty_q, pend_q, set_w;

  assign set_w = (empty_i && !empty_q) || (arm_i && empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_i;
      if (set_w)              pend_q <= 1'b1;
      else if (wr_i || ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R6
  empty_rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && !empty_q) |=> pend_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  output iid_e            id_o
);
  always_comb begin
    if      (act_i[EN_LS]) id_o = IID_LS;
    else if (act_i[EN_RX]) id_o = IID_RX;
    else if (act_i[EN_TX]) id_o = IID_TX;
    else if (act_i[EN_MS]) id_o = IID_MS;
    else                   id_o = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lsr_evt_i,
  input  logic              rx_evt_i,
  input  logic              msr_evt_i,
  input  logic              thr_empty_i,
  input  logic              lsr_rd_i,
  input  logic              rbr_rd_i,
  input  logic              msr_rd_i,
  input  logic              thr_wr_i,
  input  logic              iir_rd_i,
  input  logic              ier_we_i,
  input  logic [DATA_W-1:0] ier_wdata_i,
  output logic [DATA_W-1:0] ier_o,
  output logic [DATA_W-1:0] iir_o,
  output logic              irq_o
);
  localparam int PAD_IER = DATA_W - NSRC;
  localparam int PAD_IID = DATA_W - 3;

  logic [NSRC-1:0]   ier_q, pend, act, set_v, clr_v;
  logic [DATA_W-1:0] iir_q;
  logic              rd_q, tx_arm, tx_ack;
  iid_e              id_live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_we_i) ier_q <= ier_wdata_i[NSRC-1:0];
  end
  assign ier_o = {{PAD_IER{1'b0}}, ier_q};

  assign set_v[EN_RX] = rx_evt_i;
  assign set_v[EN_LS] = lsr_evt_i;
  assign set_v[EN_MS] = msr_evt_i;
  assign set_v[EN_TX] = 1'b0;
  assign clr_v[EN_RX] = rbr_rd_i;
  assign clr_v[EN_LS] = lsr_rd_i;
  assign clr_v[EN_MS] = msr_rd_i;
  assign clr_v[EN_TX] = thr_wr_i;

  assign tx_arm = ier_we_i && ier_wdata_i[EN_TX] && !ier_q[EN_TX];
  // ack only for the value the host is actually seeing
  assign tx_ack = iir_rd_i && !rd_q && (iir_q[2:0] == IID_TX);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == EN_TX) begin : g_tx
      irq_thre_src u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni), .empty_i(thr_empty_i), .arm_i(tx_arm),
        .wr_i(clr_v[g]), .ack_i(tx_ack), .pend_o(pend[g]));
    end else begin : g_st
      irq_sticky_src u_st (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v[g]), .clr_i(clr_v[g]),
        .pend_o(pend[g]));
    end
  end

  assign act   = pend & ier_q;
  assign irq_o = |act;

  irq_prio_enc u_enc (.act_i(act), .id_o(id_live));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iir_q <= {{PAD_IID{1'b0}}, IID_NONE};
      rd_q  <= 1'b0;
    end else begin
      rd_q <= iir_rd_i;
      if (!iir_rd_i) iir_q <= {{PAD_IID{1'b0}}, id_live};
    end
  end
  assign iir_o = iir_q;

  // R3
  irq_matches_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (id_live != IID_NONE));
  // R10
  iir_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_rd_i |=> $stable(iir_o));
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lsr_evt = 0, rx_evt = 0, ms_evt = 0, empty = 0;
  logic lsr_rd = 0, rbr_rd = 0, msr_rd = 0, thr_wr = 0, iir_rd = 0, ier_we = 0;
  logic [7:0] ier_wd = 0, ier_q, iir;
  logic irq;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lsr_evt_i(lsr_evt), .rx_evt_i(rx_evt),
    .msr_evt_i(ms_evt), .thr_empty_i(empty), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd),
    .msr_rd_i(msr_rd), .thr_wr_i(thr_wr), .iir_rd_i(iir_rd), .ier_we_i(ier_we),
    .ier_wdata_i(ier_wd), .ier_o(ier_q), .iir_o(iir), .irq_o(irq));

  // {enable[3:0], events[3:0] (b0 rx, b1 tx, b2 ls, b3 ms), expected iir}
  localparam logic [15:0] VEC [12] = '{
    16'hFF06, 16'hF304, 16'hFA02, 16'hF800, 16'hF001, 16'h0F01,
    16'hBF04, 16'hD201, 16'h2202, 16'h8F00, 16'h4406, 16'h1E01};

  task automatic step; @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all;
    lsr_rd = 1; rbr_rd = 1; msr_rd = 1; thr_wr = 1; empty = 0;
    step;
    lsr_rd = 0; rbr_rd = 0; msr_rd = 0; thr_wr = 0;
  endtask

  task automatic wr_ier(logic [7:0] v);
    ier_we = 1; ier_wd = v; step; ier_we = 0;
  endtask

  initial begin
    #(8*200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1
    chk("R1 ier", ier_q, 8'h00); chk("R1 iir", iir, 8'h01); chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1; step;

    // R4 table walk
    for (int i = 0; i < 12; i++) begin
      clear_all;
      ier_we = 1; ier_wd = {4'h0, VEC[i][15:12]};
      rx_evt = VEC[i][8]; empty = VEC[i][9]; lsr_evt = VEC[i][10]; ms_evt = VEC[i][11];
      step;
      ier_we = 0; rx_evt = 0; lsr_evt = 0; ms_evt = 0;
      step;
      chk("R4 iir", iir, VEC[i][7:0]);
      chk("R3 irq", {7'd0, irq}, {7'd0, ~VEC[i][0]});
    end

    // R2
    clear_all; wr_ier(8'hFF); chk("R2 ier", ier_q, 8'h0F);

    // R5
    lsr_evt = 1; rx_evt = 1; ms_evt = 1; step; lsr_evt = 0; rx_evt = 0; ms_evt = 0; step;
    chk("R5 start", iir, 8'h06);
    lsr_rd = 1; step; lsr_rd = 0; step; chk("R5 lsr rd", iir, 8'h04);
    rbr_rd = 1; step; rbr_rd = 0; step; chk("R5 rbr rd", iir, 8'h00);
    msr_rd = 1; step; msr_rd = 0; step; chk("R5 msr rd", iir, 8'h01);
    chk("R5 irq", {7'd0, irq}, 8'h00);

    // R6, R7, R8
    clear_all; wr_ier(8'h02);
    empty = 1; step; step;
    chk("R6 set iir", iir, 8'h02); chk("R6 set irq", {7'd0, irq}, 8'h01);
    iir_rd = 1; chk("R7 shown", iir, 8'h02); step; iir_rd = 0; step;
    chk("R7 ack irq", {7'd0, irq}, 8'h00); chk("R7 ack iir", iir, 8'h01);
    step; step; step;
    chk("R8 stays clear", {7'd0, irq}, 8'h00);
    thr_wr = 1; empty = 0; step; thr_wr = 0; empty = 1; step; step;
    chk("R8 re-raise", {7'd0, irq}, 8'h01);
    thr_wr = 1; step; thr_wr = 0; step;
    chk("R6 wr clears", {7'd0, irq}, 8'h00);

    // R9
    wr_ier(8'h00); chk("R9 off", {7'd0, irq}, 8'h00);
    wr_ier(8'h02); chk("R9 arm", {7'd0, irq}, 8'h01);

    // R7 negative: reported cause was rx
    clear_all; wr_ier(8'h03);
    rx_evt = 1; empty = 1; step; rx_evt = 0; step;
    chk("R7 rx shown", iir, 8'h04);
    iir_rd = 1; step; iir_rd = 0; step;
    rbr_rd = 1; step; rbr_rd = 0; step;
    chk("R7 tx kept", iir, 8'h02);

    // R10
    clear_all; wr_ier(8'h0F);
    ms_evt = 1; step; ms_evt = 0; step; chk("R10 pre", iir, 8'h00);
    iir_rd = 1; step; lsr_evt = 1; step; lsr_evt = 0; step;
    chk("R10 frozen", iir, 8'h00);
    iir_rd = 0; step; chk("R10 release", iir, 8'h06);

    // R11
    clear_all; wr_ier(8'h00);
    ms_evt = 1; step; ms_evt = 0; step;
    chk("R11 masked irq", {7'd0, irq}, 8'h00); chk("R11 masked iir", iir, 8'h01);
    wr_ier(8'h08); step;
    chk("R11 enabled irq", {7'd0, irq}, 8'h01); chk("R11 enabled iir", iir, 8'h00);

    // R12
    clear_all; wr_ier(8'h04);
    lsr_evt = 1; lsr_rd = 1; step; lsr_evt = 0; lsr_rd = 0; step;
    chk("R12 irq", {7'd0, irq}, 8'h01); chk("R12 iir", iir, 8'h06);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule